// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block tracks instructions from the moment they are issued until they retire in program order. A front end claims one slot per instruction and gets back a small tag. Each slot records the instruction's kind, its destination and, later, its result. Execution units return results by tag in any order. The buffer retires completed slots from the oldest end, up to four per cycle. It tells the register file which values to write, and tells the store path which buffered stores may now go to memory.

A register status table maps each architectural register to the slot that will produce its next value. An operand lookup can therefore return either a finished speculative value or the tag to wait for. A branch result flagged as mispredicted discards every slot younger than the branch, together with the register mappings that pointed into the discarded slots.

Top module: `spec_rob`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready` is 1, `cm_valid` is 0 and a lookup of any register reports `lk_busy` = 0.
- R2: Tags are handed out in ring order. The first tag is 0, each accepted allocation advances the tag by one modulo 16, and `alloc_tag` shows the next tag. With 16 slots held, `alloc_ready` is 0 and a request is dropped.
- R3: A result write marks its slot complete and stores the value. A write or mispredict flag aimed at a tag that is not currently held has no effect.
- R4: Retirement follows program order. In the cycle after the write that completes the oldest slot, lanes 0..n-1 of `cm_valid` show the n oldest consecutive completed slots, with n at most 4, and they retire at the next edge. Retirement stops at the first incomplete slot.
- R5: A retiring register op drives `rf_we` for its lane. A retiring store drives `st_release`. A retiring branch drives neither. `cm_dest` and `cm_value` carry the slot's destination and result.
- R6: Kind encoding on `alloc_kind` and `cm_kind` is 2'b00 branch, 2'b01 store, 2'b10 register op. The register number of a register op sits in the low 5 bits of its destination.
- R7: Allocating a register op maps its destination register to the new tag. A lookup of a mapped register returns `lk_busy` = 1 and `lk_tag`. `lk_ready` = 1 and `lk_value` appear once that slot is complete.
- R8: Retiring a register op clears its register mapping only if the mapping still names the retiring slot; a younger producer's mapping stays.
- R9: A result write with `wr_mispredict` = 1 to a held branch slot discards all younger slots. The next tag handed out is the branch tag plus one, and `alloc_ready` is 0 in that cycle so that no allocation happens.
- R10: A flush clears every register mapping that points at a discarded slot.
- R11: `wr_mispredict` on a store or register op slot is a plain result write and discards nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Request a slot |
| alloc_kind | input | 2 | Instruction kind (R6) |
| alloc_dest | input | 16 | Store address or register number |
| alloc_ready | output | 1 | Slot can be granted this cycle |
| alloc_tag | output | 4 | Tag the next granted slot receives |
| wr_valid | input | 1 | Result write |
| wr_tag | input | 4 | Slot being written |
| wr_value | input | 32 | Result value |
| wr_mispredict | input | 1 | Branch result was mispredicted |
| lk_reg | input | 5 | Register to look up |
| lk_busy | output | 1 | Register has a pending producer |
| lk_ready | output | 1 | Producer's result is available |
| lk_tag | output | 4 | Producer slot |
| lk_value | output | 32 | Producer's result |
| cm_valid | output | 4 | Lanes retiring at the next edge |
| cm_kind | output | 8 | Kind per lane, 2 bits each |
| cm_dest | output | 64 | Destination per lane, 16 bits each |
| cm_value | output | 128 | Value per lane, 32 bits each |
| rf_we | output | 4 | Register file write per lane |
| st_release | output | 4 | Store may go to memory per lane |

## Verification
A result write sampled at one edge sets the slot's completion. The retire lanes and a lookup's ready flag show it combinationally in the following cycle, and those slots leave at the edge after that. `alloc_ready` responds in the same cycle to a mispredict write on the inputs. The bench applies inputs shortly after a rising edge and updates its queue model just after the edge that samples them. A monitor compares the lanes, `alloc_ready` and the lookup at each falling edge, then pops the retired entries. Directed checks read the combinational outputs just after the edge that carried the stimulus.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    KIND_BRANCH = 2'b00,
    KIND_STORE  = 2'b01,
    KIND_REGOP  = 2'b10,
    KIND_RSVD   = 2'b11
  } rob_kind_e;

  // Distance walked forward from one ring position to another.
  function automatic int unsigned ring_dist(int unsigned from_p, int unsigned to_p,
                                            int unsigned mask);
    return (to_p - from_p) & mask;
  endfunction

  // Ring position a given number of steps ahead.
  function automatic int unsigned ring_step(int unsigned base, int unsigned step,
                                            int unsigned mask);
    return (base + step) & mask;
  endfunction
endpackage

// File: rtl/rob_retire_pick.sv
module rob_retire_pick
  import rob_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LANES = 4,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = TAG_W + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [TAG_W-1:0]            head,
  input  logic [CNT_W-1:0]            count,
  input  logic [DEPTH-1:0]            done_vec,
  output logic [LANES-1:0]            lane_go,
  output logic [LANES-1:0][TAG_W-1:0] lane_idx,
  output logic [CNT_W-1:0]            ncommit
);
  logic run_chain;

  always_comb begin
    run_chain = 1'b1;
    ncommit   = '0;
    for (int k = 0; k < LANES; k++) begin
      lane_idx[k] = TAG_W'(ring_step(int'(head), k, DEPTH - 1));
      lane_go[k]  = run_chain && (CNT_W'(k) < count) && done_vec[lane_idx[k]];
      run_chain   = lane_go[k];
      ncommit     = ncommit + CNT_W'(lane_go[k]);
    end
  end

  AST_NO_OVERCOMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ncommit <= count); // R4
endmodule

// File: rtl/rob_rename_map.sv
module rob_rename_map
  import rob_pkg::*;
#(
  parameter int NREG  = 32,
  parameter int DEPTH = 16,
  parameter int LANES = 4,
  localparam int REG_W = $clog2(NREG),
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        set_en,
  input  logic [REG_W-1:0]            set_reg,
  input  logic [TAG_W-1:0]            set_tag,
  input  logic [LANES-1:0]            clr_en,
  input  logic [LANES-1:0][REG_W-1:0] clr_reg,
  input  logic [LANES-1:0][TAG_W-1:0] clr_tag,
  input  logic                        flush,
  input  logic [DEPTH-1:0]            squash,
  input  logic [REG_W-1:0]            lk_reg,
  output logic                        lk_busy,
  output logic [TAG_W-1:0]            lk_tag
);
  logic [NREG-1:0]  map_v;
  logic [TAG_W-1:0] map_t [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_v <= '0;
      for (int r = 0; r < NREG; r++) map_t[r] <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (flush && map_v[r] && squash[map_t[r]]) map_v[r] <= 1'b0;   // R10
        for (int k = 0; k < LANES; k++)
          if (clr_en[k] && clr_reg[k] == REG_W'(r) && clr_tag[k] == map_t[r])
            map_v[r] <= 1'b0;                                           // R8
        if (set_en && set_reg == REG_W'(r)) begin
          map_v[r] <= 1'b1;
          map_t[r] <= set_tag;
        end
      end
    end
  end

  assign lk_busy = map_v[lk_reg];
  assign lk_tag  = map_t[lk_reg];

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> map_v[$past(set_reg)] && map_t[$past(set_reg)] == $past(set_tag)); // R7
endmodule

// File: rtl/spec_rob.sv
module spec_rob
  import rob_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int LANES  = 4,
  parameter int NREG   = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int REG_W = $clog2(NREG)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    alloc_valid,
  input  logic [1:0]              alloc_kind,
  input  logic [ADDR_W-1:0]       alloc_dest,
  output logic                    alloc_ready,
  output logic [TAG_W-1:0]        alloc_tag,
  input  logic                    wr_valid,
  input  logic [TAG_W-1:0]        wr_tag,
  input  logic [DATA_W-1:0]       wr_value,
  input  logic                    wr_mispredict,
  input  logic [REG_W-1:0]        lk_reg,
  output logic                    lk_busy,
  output logic                    lk_ready,
  output logic [TAG_W-1:0]        lk_tag,
  output logic [DATA_W-1:0]       lk_value,
  output logic [LANES-1:0]        cm_valid,
  output logic [LANES*2-1:0]      cm_kind,
  output logic [LANES*ADDR_W-1:0] cm_dest,
  output logic [LANES*DATA_W-1:0] cm_value,
  output logic [LANES-1:0]        rf_we,
  output logic [LANES-1:0]        st_release
);
  localparam int CNT_W = TAG_W + 1;
  localparam int MASK  = DEPTH - 1;

  logic [TAG_W-1:0]  head_q, tail_q;
  logic [CNT_W-1:0]  count_q, ncommit, keep_cnt;
  logic [DEPTH-1:0]  busy_q, done_q, squash;
  rob_kind_e         kind_q  [DEPTH];
  logic [ADDR_W-1:0] dest_q  [DEPTH];
  logic [DATA_W-1:0] value_q [DEPTH];

  // Named events
  logic write_hit, flush_evt, alloc_fire;
  logic [LANES-1:0]            lane_go;
  logic [LANES-1:0][TAG_W-1:0] lane_idx;
  logic [LANES-1:0][REG_W-1:0] clr_reg;

  assign write_hit   = wr_valid && busy_q[wr_tag];
  assign flush_evt   = write_hit && wr_mispredict && kind_q[wr_tag] == KIND_BRANCH;
  assign alloc_ready = (count_q < CNT_W'(DEPTH)) && !flush_evt;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_tag   = tail_q;
  assign keep_cnt    = CNT_W'(ring_dist(int'(head_q), int'(wr_tag), MASK)) + CNT_W'(1);

  // A held slot is discarded when it lies further from the head than the branch.
  for (genvar i = 0; i < DEPTH; i++) begin : g_squash
    assign squash[i] = flush_evt && busy_q[i] &&
      (ring_dist(int'(head_q), i, MASK) > ring_dist(int'(head_q), int'(wr_tag), MASK));
  end

  rob_retire_pick #(.DEPTH(DEPTH), .LANES(LANES)) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .head     (head_q),
    .count    (count_q),
    .done_vec (done_q),
    .lane_go  (lane_go),
    .lane_idx (lane_idx),
    .ncommit  (ncommit)
  );

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      cm_valid[k]                   = lane_go[k];
      cm_kind[k*2 +: 2]             = kind_q[lane_idx[k]];
      cm_dest[k*ADDR_W +: ADDR_W]   = dest_q[lane_idx[k]];
      cm_value[k*DATA_W +: DATA_W]  = value_q[lane_idx[k]];
      rf_we[k]      = lane_go[k] && kind_q[lane_idx[k]] == KIND_REGOP;
      st_release[k] = lane_go[k] && kind_q[lane_idx[k]] == KIND_STORE;
      clr_reg[k]    = dest_q[lane_idx[k]][REG_W-1:0];
    end
  end

  rob_rename_map #(.NREG(NREG), .DEPTH(DEPTH), .LANES(LANES)) u_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (alloc_fire && rob_kind_e'(alloc_kind) == KIND_REGOP),
    .set_reg (alloc_dest[REG_W-1:0]),
    .set_tag (tail_q),
    .clr_en  (rf_we),
    .clr_reg (clr_reg),
    .clr_tag (lane_idx),
    .flush   (flush_evt),
    .squash  (squash),
    .lk_reg  (lk_reg),
    .lk_busy (lk_busy),
    .lk_tag  (lk_tag)
  );

  assign lk_ready = lk_busy && done_q[lk_tag];
  assign lk_value = value_q[lk_tag];

  // Control state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
      busy_q  <= '0;
      done_q  <= '0;
    end else begin
      if (write_hit) done_q[wr_tag] <= 1'b1;
      for (int k = 0; k < LANES; k++)
        if (lane_go[k]) begin
          busy_q[lane_idx[k]] <= 1'b0;
          done_q[lane_idx[k]] <= 1'b0;
        end
      for (int i = 0; i < DEPTH; i++)
        if (squash[i]) begin
          busy_q[i] <= 1'b0;
          done_q[i] <= 1'b0;
        end
      if (alloc_fire) begin
        busy_q[tail_q] <= 1'b1;
        done_q[tail_q] <= 1'b0;
      end
      head_q <= head_q + ncommit[TAG_W-1:0];
      if (flush_evt) begin
        tail_q  <= wr_tag + TAG_W'(1);
        count_q <= keep_cnt - ncommit;
      end else begin
        tail_q  <= tail_q + TAG_W'(alloc_fire);
        count_q <= count_q + CNT_W'(alloc_fire) - ncommit;
      end
    end
  end

  // Payload storage, no reset needed
  always_ff @(posedge clk) begin
    if (alloc_fire) begin
      kind_q[tail_q] <= rob_kind_e'(alloc_kind);
      dest_q[tail_q] <= alloc_dest;
    end
    if (write_hit) value_q[wr_tag] <= wr_value;
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH)); // R2
  AST_ALLOC_OCCUPIES: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> busy_q[$past(tail_q)]); // R2
  AST_RETIRE_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
    lane_go[0] |-> done_q[head_q] && busy_q[head_q]); // R4
  AST_FLUSH_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    flush_evt |=> tail_q == $past(wr_tag) + TAG_W'(1)); // R9
  AST_FLUSH_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
    flush_evt |=> count_q <= $past(count_q)); // R9
  AST_MAP_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_busy |-> busy_q[lk_tag]); // R10
endmodule

// File: tb/spec_rob_test.sv
`timescale 1ns/1ps
module spec_rob_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         alloc_valid = 1'b0;
  logic [1:0]   alloc_kind = 2'b00;
  logic [15:0]  alloc_dest = '0;
  logic         alloc_ready;
  logic [3:0]   alloc_tag;
  logic         wr_valid = 1'b0;
  logic [3:0]   wr_tag = '0;
  logic [31:0]  wr_value = '0;
  logic         wr_mispredict = 1'b0;
  logic [4:0]   lk_reg = '0;
  logic         lk_busy, lk_ready;
  logic [3:0]   lk_tag;
  logic [31:0]  lk_value;
  logic [3:0]   cm_valid, rf_we, st_release;
  logic [7:0]   cm_kind;
  logic [63:0]  cm_dest;
  logic [127:0] cm_value;

  always #10 clk = ~clk;   // 50 MHz

  spec_rob uut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_kind(alloc_kind), .alloc_dest(alloc_dest),
    .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .wr_valid(wr_valid), .wr_tag(wr_tag), .wr_value(wr_value), .wr_mispredict(wr_mispredict),
    .lk_reg(lk_reg), .lk_busy(lk_busy), .lk_ready(lk_ready), .lk_tag(lk_tag), .lk_value(lk_value),
    .cm_valid(cm_valid), .cm_kind(cm_kind), .cm_dest(cm_dest), .cm_value(cm_value),
    .rf_we(rf_we), .st_release(st_release)
  );

  typedef struct { int tag; int kind; int dest; int value; bit done; } item_t;
  item_t q[$];
  bit    map_v [32];
  int    map_t [32];
  int    exp_tail = 0;
  bit    cur_flush = 1'b0;
  bit    mon_on = 1'b0;
  int    n_chk = 0, n_bad = 0;
  int    last_tag;

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int find_pos(int tag);
    for (int i = 0; i < q.size(); i++) if (q[i].tag == tag) return i;
    return -1;
  endfunction

  // Scoreboard monitor: compares retire lanes, ready and lookup against the queue model.
  always @(negedge clk) begin
    if (mon_on) begin
      int n;
      bit run;
      int pos;
      n = 0; run = 1'b1;
      for (int k = 0; k < 4; k++)
        if (run && k < q.size() && q[k].done) n++; else run = 1'b0;
      for (int k = 0; k < 4; k++) begin
        check("R4 lane valid", cm_valid[k], k < n);
        if (k < n) begin
          check("R6 lane kind", cm_kind[k*2 +: 2], q[k].kind);
          check("R5 lane dest", cm_dest[k*16 +: 16], q[k].dest);
          check("R5 lane value", cm_value[k*32 +: 32], q[k].value);
          check("R5 rf_we", rf_we[k], q[k].kind == 2);
          check("R5 st_release", st_release[k], q[k].kind == 1);
        end
      end
      check("R2/R9 alloc_ready", alloc_ready, q.size() < 16 && !cur_flush);
      check("R7 lookup busy", lk_busy, map_v[lk_reg]);
      if (map_v[lk_reg]) begin
        check("R7 lookup tag", lk_tag, map_t[lk_reg]);
        pos = find_pos(map_t[lk_reg]);
        check("R7 lookup ready", lk_ready, pos >= 0 && q[pos].done);
        if (pos >= 0 && q[pos].done) check("R7 lookup value", lk_value, q[pos].value);
      end
      for (int k = 0; k < n; k++) begin
        if (q[0].kind == 2 && map_v[q[0].dest] && map_t[q[0].dest] == q[0].tag)
          map_v[q[0].dest] = 1'b0;
        void'(q.pop_front());
      end
    end
  end

  // Driver: inputs applied 2 ns after an edge, model updated 1 ns after the next edge.
  task automatic op(bit av, int ak, int ad, bit wv, int wt, int wval, bit wm);
    int  pos;
    bit  rdy;
    alloc_valid = av; alloc_kind = 2'(ak); alloc_dest = 16'(ad);
    wr_valid = wv; wr_tag = 4'(wt); wr_value = wval; wr_mispredict = wm;
    pos = wv ? find_pos(wt) : -1;
    cur_flush = wv && wm && pos >= 0 && q[pos].kind == 0;
    #1;
    rdy = alloc_ready;
    if (av && rdy) begin
      check("R2 alloc tag", alloc_tag, exp_tail);
      last_tag = alloc_tag;
    end
    @(posedge clk); #1;
    if (wv) begin
      pos = find_pos(wt);
      if (pos >= 0) begin
        q[pos].done = 1'b1; q[pos].value = wval;
        if (wm && q[pos].kind == 0) begin
          for (int j = q.size() - 1; j > pos; j--) begin
            if (q[j].kind == 2 && map_v[q[j].dest] && map_t[q[j].dest] == q[j].tag)
              map_v[q[j].dest] = 1'b0;
            q.delete(j);
          end
          exp_tail = (wt + 1) % 16;
        end
      end
    end
    if (av && rdy) begin
      item_t it;
      it.tag = exp_tail; it.kind = ak; it.dest = ad; it.value = 0; it.done = 1'b0;
      q.push_back(it);
      if (ak == 2) begin map_v[ad] = 1'b1; map_t[ad] = exp_tail; end
      exp_tail = (exp_tail + 1) % 16;
    end
    alloc_valid = 1'b0; wr_valid = 1'b0; wr_mispredict = 1'b0; cur_flush = 1'b0;
    #1;
  endtask

  task automatic alloc(int k, int d);  op(1, k, d, 0, 0, 0, 0); endtask
  task automatic write(int t, int v, bit m); op(0, 0, 0, 1, t, v, m); endtask
  task automatic idle();               op(0, 0, 0, 0, 0, 0, 0); endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    int t[8];
    int tf[16];
    for (int r = 0; r < 32; r++) begin map_v[r] = 1'b0; map_t[r] = 0; end
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    lk_reg = 5; #1;
    check("R1 reset cm_valid", cm_valid, 0);
    check("R1 reset alloc_ready", alloc_ready, 1);
    check("R1 reset lk_busy", lk_busy, 0);
    check("R1 reset alloc_tag", alloc_tag, 0);
    mon_on = 1'b1;

    // Mixed kinds, out-of-order results, four-lane retirement
    alloc(2, 5);      t[0] = last_tag;
    alloc(1, 'h1234); t[1] = last_tag;
    alloc(0, 0);      t[2] = last_tag;
    alloc(2, 5);      t[3] = last_tag;
    alloc(2, 7);      t[4] = last_tag;
    check("R2 tags sequential", t[4], 4);
    check("R7 lookup names youngest producer", lk_tag, t[3]);
    check("R7 lookup pending not ready", lk_ready, 0);
    write(t[3], 'hAAA3, 0);
    check("R7 lookup ready after result", lk_ready, 1);
    check("R7 lookup value", lk_value, 'hAAA3);
    check("R4 no retire while oldest incomplete", cm_valid, 0);
    write(t[1], 'hBBB1, 0);
    write(t[2], 'h1, 0);
    write(t[4], 'hCCC4, 0);
    write(t[0], 'hDDD0, 0);
    check("R4 four lanes retire together", cm_valid, 4'b1111);
    check("R5 store lane release", st_release, 4'b0010);
    check("R5 regop lane writes", rf_we, 4'b1001);
    idle();
    check("R4 fifth slot retires next", cm_valid, 4'b0001);
    idle();

    // Retirement clears a mapping only when it still names the slot
    lk_reg = 9;
    alloc(2, 9); t[0] = last_tag;
    alloc(2, 9); t[1] = last_tag;
    write(t[0], 'h90, 0);
    idle();
    check("R8 younger mapping kept busy", lk_busy, 1);
    check("R8 younger mapping tag", lk_tag, t[1]);
    write(t[1], 'h91, 0);
    idle();
    check("R8 mapping cleared by own producer", lk_busy, 0);

    // Retirement stops at first incomplete slot
    for (int i = 0; i < 6; i++) begin alloc(2, 10 + i); t[i] = last_tag; end
    write(t[1], 'h11, 0);
    write(t[2], 'h12, 0);
    write(t[4], 'h14, 0);
    write(t[0], 'h10, 0);
    check("R4 stop at gap", cm_valid, 4'b0111);
    write(t[3], 'h13, 0);
    check("R4 resume after gap", cm_valid, 4'b0011);
    write(t[5], 'h15, 0);
    check("R4 last slot", cm_valid, 4'b0001);
    idle();

    // Mispredicted branch flush with concurrent allocation attempt
    lk_reg = 3;
    alloc(2, 3);      t[0] = last_tag;
    alloc(0, 0);      t[1] = last_tag;
    alloc(2, 3);      t[2] = last_tag;
    alloc(1, 'h40);   t[3] = last_tag;
    write(t[2], 'h22, 0);
    write(t[3], 'h33, 0);
    op(1, 2, 20, 1, t[1], 0, 1);
    check("R10 mapping to discarded slot cleared", lk_busy, 0);
    check("R9 nothing retires past incomplete", cm_valid, 0);
    check("R9 tag restarts after branch", alloc_tag, (t[1] + 1) % 16);
    alloc(2, 21); t[4] = last_tag;
    check("R9 allocated tag after flush", t[4], (t[1] + 1) % 16);
    write(t[0], 'h20, 0);
    check("R9 only older and branch retire", cm_valid, 4'b0011);
    idle();
    // Mispredict aimed at the freed branch tag must do nothing
    write(t[1], 'h0, 1);
    check("R3 stale tag keeps tail", alloc_tag, (t[4] + 1) % 16);
    write(t[4], 'h44, 0);
    check("R3 live slot still retires", cm_valid, 4'b0001);
    idle();

    // Mispredict flag on a store is a plain write
    alloc(1, 'h50); t[0] = last_tag;
    alloc(2, 22);   t[1] = last_tag;
    write(t[0], 'h55, 1);
    check("R11 store retires, no discard", cm_valid, 4'b0001);
    check("R11 younger slot still mapped", alloc_tag, (t[1] + 1) % 16);
    write(t[1], 'h66, 0);
    check("R11 younger slot retires", cm_valid, 4'b0001);
    idle();

    // Fill to capacity, rejected request, reverse-order completion, drain
    for (int i = 0; i < 16; i++) begin alloc(2, i); tf[i] = last_tag; end
    check("R2 full blocks ready", alloc_ready, 0);
    alloc(2, 30);
    check("R2 rejected request keeps tail", alloc_tag, exp_tail);
    for (int i = 15; i >= 0; i--) write(tf[i], 'h1000 + i, 0);
    check("R4 full width retire from full", cm_valid, 4'b1111);
    for (int i = 0; i < 8 && q.size() > 0; i++) idle();
    check("R2 drained ready", alloc_ready, 1);
    check("R4 drained no lanes", cm_valid, 0);
    summary();
  end
endmodule